// File: doc/BRIEF.md
# Per-Processor Lock Flag Array

This block keeps one mutual-exclusion flag for each of `N_PE` processor elements. Every element presents a 2-bit request code and a 32-bit operand each cycle. A take request (blocking or non-blocking) can only ever raise the flag that belongs to the requesting element. A release request may come from any element: its operand is read as a bitmask, and every element whose bit is set has its flag dropped.

Simultaneous requests are resolved inside the block. Releases from several elements in the same cycle merge into one mask. When a release and a take land on the same flag in one cycle, the release wins. For a non-blocking take, the block reports in the same cycle whether the flag was already held. For a blocking take, it holds the requester in a stall while the flag is held. The flags themselves are registered and update on the rising clock edge.

Top module: `pe_lock_flags`

## Requirements
- R1: An active-low reset (`rst_n` = 0) clears every flag, both at start-up and when asserted mid-run.
- R2: A request code of 1 (blocking take) or 2 (non-blocking take) from element i sets `flags_o[i]` on the next rising edge, unless a release targets i in that cycle.
- R3: A take request never sets the flag of any element other than the one issuing it.
- R4: A request code of 3 (release) from any element clears, on the next edge, every flag j for which bit j of that element's operand is 1. Operand bits at positions `N_PE` and above are ignored.
- R5: Release masks issued by several elements in the same cycle take effect as their bitwise OR.
- R6: When a release and a take target the same flag in the same cycle, the flag is 0 after the edge.
- R7: `busy_o[i]` is 1 in the same cycle in which element i presents code 2 while `flags_o[i]` is already 1. Otherwise it is 0.
- R8: `stall_o[i]` is 1 in the same cycle in which element i presents code 1 while `flags_o[i]` is 1. A stalled take leaves the flag set.
- R9: A flag with no take from its owner and no release bit aimed at it keeps its value. Request code 0 means idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 2*N_PE | Request code per element, element i at bits [2i+1:2i]: 0 idle, 1 blocking take, 2 non-blocking take, 3 release |
| operand_i | input | OPW*N_PE | Operand per element, element i at bits [OPW*i +: OPW]; the release mask uses the low N_PE bits |
| flags_o | output | N_PE | Current lock flag of each element |
| busy_o | output | N_PE | Non-blocking take found the flag already set |
| stall_o | output | N_PE | Blocking take must wait this cycle |

## Verification
The assertions assume that `op_i` and `operand_i` are stable and known around each rising edge, and that `OPW` is at least `N_PE`, so that every element has a mask bit. The bench changes inputs only on falling edges and leaves the default widths unchanged. It drives directed cases for each priority and masking rule, then a long run of random codes and operands. After every edge it compares all outputs with a behavioural model that tracks each flag on its own.

// File: rtl/pe_lock_flags.sv
module pe_lock_flags #(
  parameter int N_PE = 4,
  parameter int OPW  = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*N_PE-1:0]     op_i,
  input  logic [OPW*N_PE-1:0]   operand_i,
  output logic [N_PE-1:0]       flags_o,
  output logic [N_PE-1:0]       busy_o,
  output logic [N_PE-1:0]       stall_o
);

  localparam logic [1:0] OP_LOCK = 2'd1;
  localparam logic [1:0] OP_TRY  = 2'd2;
  localparam logic [1:0] OP_REL  = 2'd3;

  logic [N_PE-1:0] take;
  logic [N_PE-1:0] drop;

  always_comb begin
    drop = '0;
    for (int i = 0; i < N_PE; i++)
      if (op_i[2*i +: 2] == OP_REL)
        drop = drop | operand_i[OPW*i +: N_PE];
  end

  for (genvar g = 0; g < N_PE; g++) begin : g_pe
    logic [1:0] code;
    assign code       = op_i[2*g +: 2];
    assign take[g]    = (code == OP_LOCK) || (code == OP_TRY);
    assign busy_o[g]  = (code == OP_TRY)  && flags_o[g];
    assign stall_o[g] = (code == OP_LOCK) && flags_o[g];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) flags_o[g] <= 1'b0;
      else        flags_o[g] <= (flags_o[g] | take[g]) & ~drop[g];

    p_take_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      take[g] && !drop[g] |=> flags_o[g]);
    p_rise_owner_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[g]) |-> $past(take[g]));
    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drop[g] |=> !flags_o[g]);
    p_stall_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stall_o[g] && !drop[g] |=> flags_o[g]);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !take[g] && !drop[g] |=> $stable(flags_o[g]));
  end

endmodule

// File: tb/pe_lock_flags_test.sv
module pe_lock_flags_test;
  localparam int N = 4;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic [2*N-1:0] op_i = '0;
  logic [W*N-1:0] operand_i = '0;
  logic [N-1:0] flags_o, busy_o, stall_o;

  int checks = 0;
  int failures = 0;
  logic [N-1:0] model = '0;

  pe_lock_flags #(.N_PE(N), .OPW(W)) uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .operand_i(operand_i),
    .flags_o(flags_o), .busy_o(busy_o), .stall_o(stall_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic cycle(string tag, logic [1:0] c0, logic [1:0] c1, logic [1:0] c2,
                       logic [1:0] c3, logic [W-1:0] m0, logic [W-1:0] m1,
                       logic [W-1:0] m2, logic [W-1:0] m3);
    logic [1:0] cs [N];
    logic [W-1:0] ms [N];
    logic [N-1:0] eb, es, nxt;
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
    ms[0] = m0; ms[1] = m1; ms[2] = m2; ms[3] = m3;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      op_i[2*i +: 2] = cs[i];
      operand_i[W*i +: W] = ms[i];
    end
    nxt = model;
    for (int i = 0; i < N; i++) begin
      eb[i] = (cs[i] == 2'd2) && model[i];
      es[i] = (cs[i] == 2'd1) && model[i];
      if (cs[i] == 2'd1 || cs[i] == 2'd2) nxt[i] = 1'b1;
    end
    for (int i = 0; i < N; i++)
      if (cs[i] == 2'd3)
        for (int j = 0; j < N; j++)
          if (ms[i][j]) nxt[j] = 1'b0;
    #(CLK_PERIOD/4);
    check("R7", "busy_o", busy_o, eb);
    check("R8", "stall_o", stall_o, es);
    @(posedge clk);
    model = nxt;
    #1;
    check(tag, "flags_o", flags_o, model);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 1);
    check("R1", "flags_o after reset", flags_o, '0);
    @(negedge clk); rst_n = 1;
    cycle("R2", 2'd1, 0, 0, 0, 0, 0, 0, 0);            // PE0 LOCK
    cycle("R3", 0, 2'd2, 0, 0, 0, 0, 0, 0);            // PE1 TRYLOCK, only flag1 joins
    cycle("R7", 0, 2'd2, 0, 0, 0, 0, 0, 0);            // busy reported
    cycle("R8", 2'd1, 0, 0, 0, 0, 0, 0, 0);            // stall, flag kept
    cycle("R4", 0, 0, 2'd3, 0, 0, 0, 32'h1, 0);        // PE2 releases PE0
    cycle("R9", 0, 0, 0, 0, 0, 0, 0, 0);               // idle hold
    cycle("R4", 0, 0, 0, 2'd3, 0, 0, 0, 32'hFFFF_FFF0); // high bits ignored
    cycle("R2", 0, 0, 2'd1, 2'd2, 0, 0, 0, 0);
    cycle("R5", 2'd3, 0, 0, 2'd3, 32'h2, 0, 0, 32'h8); // merged releases
    cycle("R6", 2'd3, 0, 2'd1, 0, 32'h4, 0, 0, 0);     // release beats take
    cycle("R6", 0, 2'd2, 0, 0, 0, 0, 0, 0);
    cycle("R6", 0, 2'd2, 2'd3, 0, 0, 0, 32'h2, 0);     // TRYLOCK vs release
    cycle("R4", 0, 2'd1, 0, 0, 0, 0, 0, 0);
    cycle("R4", 0, 2'd3, 0, 0, 0, 32'h2, 0, 0);        // self release
    for (int k = 0; k < 400; k++)
      cycle("R9", 2'($urandom), 2'($urandom), 2'($urandom), 2'($urandom),
            $urandom & 32'hF00F, $urandom & 32'h3, $urandom & 32'hC, $urandom);
    cycle("R1", 2'd1, 2'd1, 2'd1, 2'd1, 0, 0, 0, 0);
    @(negedge clk); rst_n = 0; model = '0;
    #1 check("R1", "flags_o mid-run reset", flags_o, '0);
    @(negedge clk); op_i = '0; rst_n = 1;
    cycle("R1", 0, 0, 0, 0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule